// File: doc/BRIEF.md
# Texel Address and Filter Setup

This block sits at the front of a texture sampling pipeline. It takes a signed fixed-point texture coordinate pair, with six fractional bits (1/64 texel steps), and works out which RGB565 texels a later stage must fetch and how they should be blended. Texels are two bytes each and stored row by row, so the texel at column `tx`, row `ty` is at `base + 2*(ty*hres + tx)`.

Two mask inputs select the sampling behaviour; there are no separate mode bits. The low six bits of the horizontal mask choose between nearest-texel and bilinear sampling. For each axis, the bits above those six are ANDed with that axis's resolution, and the result chooses between clamping and wrapping. The block outputs four texel byte addresses, two 6-bit blend weights and a bilinear flag on a valid/ready stream with one register stage. Fetching the texels and blending them are done elsewhere.

Top module: `texel_fetch_plan`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `blend_en` is 1 exactly when `tex_hmask[5:0]` is greater than 0x20. The value 0x20 itself gives nearest sampling.
- R3: In nearest mode, `weight_u` and `weight_v` are 0. All four addresses equal the address of texel (floor(u/64), floor(v/64)) after the axis rule is applied.
- R4: In bilinear mode, `weight_u = coord_u[5:0]` and `weight_v = coord_v[5:0]`. `texel_a`, `texel_b`, `texel_c` and `texel_d` address (tx,ty), (tx+1,ty), (tx,ty+1) and (tx+1,ty+1) respectively. Each neighbour index goes through its axis rule separately.
- R5: An axis clamps when (its mask shifted right by 6) AND (its resolution) is nonzero. Otherwise the axis wraps.
- R6: A wrapping axis maps index i to i mod res, in the range 0..res-1. Negative indices wrap in from the top.
- R7: A clamping axis maps negative indices to 0, indices of res or more to res-1, and leaves all others unchanged.
- R8: Every address equals `tex_base + 2*(ty*tex_hres + tx)`, modulo 2^ADDR_W. Bit 0 of each address equals bit 0 of the base.
- R9: A request is accepted when `in_valid && in_ready`, and its result appears with `out_valid` on the next cycle. `in_ready` is `!out_valid || out_ready`. While `out_valid && !out_ready`, all outputs stay unchanged.
- R10: An axis whose resolution is 0 uses index 0 on that axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| coord_u | input | COORD_W | Horizontal coordinate, signed, 6 fractional bits |
| coord_v | input | COORD_W | Vertical coordinate, signed, 6 fractional bits |
| tex_base | input | ADDR_W | Texture byte base address (2-byte aligned) |
| tex_hres | input | RES_W | Texture width in texels |
| tex_vres | input | RES_W | Texture height in texels |
| tex_hmask | input | MASK_W | Horizontal mask: filter select in bits 5:0, clamp bits above |
| tex_vmask | input | MASK_W | Vertical mask: clamp bits above bit 5 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| texel_a | output | ADDR_W | Address of (tx,ty) |
| texel_b | output | ADDR_W | Address of (tx+1,ty) |
| texel_c | output | ADDR_W | Address of (tx,ty+1) |
| texel_d | output | ADDR_W | Address of (tx+1,ty+1) |
| weight_u | output | 6 | Horizontal blend weight |
| weight_v | output | 6 | Vertical blend weight |
| blend_en | output | 1 | Bilinear sampling selected |

## Verification
The bench builds the block with COORD_W=12, RES_W=4 and ADDR_W=16. With these settings integer texel indices span -32..31, which is about twice the largest 4-bit resolution. A sweep over those indices therefore crosses both edges of the texture several times, in all eight combinations of clamp per axis and filter mode, for odd, even, power-of-two and maximal resolutions. Separate cases cover zero resolution, the filter threshold at 0x20 versus 0x21, mask bits that do not overlap the resolution, and output back-pressure.

// File: rtl/texmap_pkg.sv
// Shared definitions for the texel address setup block.
// Assumes coordinates use a fixed 6-bit fractional part.
package texmap_pkg;
    localparam int FRAC_W = 6;

    typedef enum logic {
        AX_WRAP  = 1'b0,
        AX_CLAMP = 1'b1
    } axis_mode_e;
endpackage

// File: rtl/texmap_axis_fold.sv
// Folds a signed integer texel index into 0..res-1 on one axis.
// Wrap mode reduces the index modulo res (the result is never negative).
// Clamp mode saturates it at 0 and res-1. A zero resolution yields 0.
module texmap_axis_fold
    import texmap_pkg::*;
#(
    parameter int IXW   = 8,
    parameter int RES_W = 4
) (
    input  logic signed [IXW-1:0]   idx,
    input  logic [RES_W-1:0]        res,
    input  axis_mode_e              mode,
    output logic [RES_W-1:0]        folded
);
    localparam int SW = ((IXW > RES_W) ? IXW : RES_W) + 2;

    logic signed [SW-1:0] idx_s;
    logic signed [SW-1:0] res_s;
    logic signed [SW-1:0] rem_s;

    assign idx_s = SW'(idx);
    assign res_s = $signed(SW'(res));

    // Apply the wrap or clamp rule to the index.
    always_comb begin
        folded = '0;
        rem_s  = '0;
        if (res != '0) begin
            if (mode == AX_CLAMP) begin
                if (idx_s < 0)
                    folded = '0;
                else if (idx_s >= res_s)
                    folded = res - 1'b1;
                else
                    folded = idx_s[RES_W-1:0];
            end else begin
                rem_s = idx_s % res_s;
                if (rem_s < 0)
                    rem_s = rem_s + res_s;
                folded = rem_s[RES_W-1:0];
            end
        end
    end
endmodule

// File: rtl/texmap_addr_gen.sv
// Converts a folded texel position into a byte address for 2-byte
// texels stored row by row. Assumes ADDR_W >= 2*RES_W+2.
module texmap_addr_gen #(
    parameter int RES_W  = 4,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [RES_W-1:0]  row_len,
    input  logic [RES_W-1:0]  tx,
    input  logic [RES_W-1:0]  ty,
    output logic [ADDR_W-1:0] addr
);
    localparam int LW = 2 * RES_W + 1;

    logic [LW-1:0] lin;

    // Linear texel index, then scaled to bytes and offset by the base.
    always_comb begin
        lin  = LW'(ty) * LW'(row_len) + LW'(tx);
        addr = base + ADDR_W'({lin, 1'b0});
    end
endmodule

// File: rtl/texel_fetch_plan.sv
// Top of the texel address setup block. It decodes the filter and
// per-axis wrap/clamp modes from the mask inputs, folds the base and
// neighbour indices on each axis, forms four corner addresses, and
// registers the result in a single valid/ready stage.
// Assumes that tex_base is even and that the configuration inputs
// are valid whenever in_valid is high.
module texel_fetch_plan
    import texmap_pkg::*;
#(
    parameter int COORD_W = 18,
    parameter int RES_W   = 11,
    parameter int ADDR_W  = 32,
    parameter int MASK_W  = 6 + RES_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [COORD_W-1:0]  coord_u,
    input  logic [COORD_W-1:0]  coord_v,
    input  logic [ADDR_W-1:0]   tex_base,
    input  logic [RES_W-1:0]    tex_hres,
    input  logic [RES_W-1:0]    tex_vres,
    input  logic [MASK_W-1:0]   tex_hmask,
    input  logic [MASK_W-1:0]   tex_vmask,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   texel_a,
    output logic [ADDR_W-1:0]   texel_b,
    output logic [ADDR_W-1:0]   texel_c,
    output logic [ADDR_W-1:0]   texel_d,
    output logic [5:0]          weight_u,
    output logic [5:0]          weight_v,
    output logic                blend_en
);
    localparam int IW  = COORD_W - FRAC_W;
    localparam int IXW = IW + 1;
    localparam logic [FRAC_W-1:0] BIL_LIMIT = FRAC_W'(32);

    // Mode decode
    logic              bil_sel;
    axis_mode_e        ax_mode [2];
    logic [RES_W-1:0]  ax_res  [2];
    logic [MASK_W-FRAC_W-1:0] h_clamp_bits, v_clamp_bits;

    assign bil_sel      = tex_hmask[FRAC_W-1:0] > BIL_LIMIT;
    assign h_clamp_bits = tex_hmask[MASK_W-1:FRAC_W];
    assign v_clamp_bits = tex_vmask[MASK_W-1:FRAC_W];
    assign ax_res[0]    = tex_hres;
    assign ax_res[1]    = tex_vres;
    assign ax_mode[0]   = (|(h_clamp_bits & tex_hres)) ? AX_CLAMP : AX_WRAP;
    assign ax_mode[1]   = (|(v_clamp_bits & tex_vres)) ? AX_CLAMP : AX_WRAP;

    // Integer texel indices (floor of coordinate / 64)
    logic signed [IW-1:0]  int_c  [2];
    logic signed [IXW-1:0] idx    [2][2];
    logic [RES_W-1:0]      folded [2][2];

    assign int_c[0] = coord_u[COORD_W-1:FRAC_W];
    assign int_c[1] = coord_v[COORD_W-1:FRAC_W];

    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        // Base index and its neighbour; nearest mode reuses the base.
        always_comb begin
            idx[ax][0] = IXW'(int_c[ax]);
            idx[ax][1] = bil_sel ? (idx[ax][0] + {{(IXW-1){1'b0}}, 1'b1})
                                 : idx[ax][0];
        end
        for (genvar off = 0; off < 2; off++) begin : g_off
            texmap_axis_fold #(.IXW(IXW), .RES_W(RES_W)) fold_i (
                .idx    (idx[ax][off]),
                .res    (ax_res[ax]),
                .mode   (ax_mode[ax]),
                .folded (folded[ax][off])
            );
        end
    end

    // Corner addresses: bit 0 of k picks the x neighbour, bit 1 the y neighbour
    logic [ADDR_W-1:0] corner [4];

    for (genvar k = 0; k < 4; k++) begin : g_corner
        texmap_addr_gen #(.RES_W(RES_W), .ADDR_W(ADDR_W)) agen_i (
            .base    (tex_base),
            .row_len (tex_hres),
            .tx      (folded[0][k % 2]),
            .ty      (folded[1][k / 2]),
            .addr    (corner[k])
        );
    end

    // Output stage
    logic accept;
    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    // Valid flag: loads on any slot release, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (in_ready)
            out_valid <= in_valid;
    end

    // Result registers: capture only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            texel_a  <= '0;
            texel_b  <= '0;
            texel_c  <= '0;
            texel_d  <= '0;
            weight_u <= '0;
            weight_v <= '0;
            blend_en <= 1'b0;
        end else if (accept) begin
            texel_a  <= corner[0];
            texel_b  <= corner[1];
            texel_c  <= corner[2];
            texel_d  <= corner[3];
            weight_u <= bil_sel ? coord_u[FRAC_W-1:0] : '0;
            weight_v <= bil_sel ? coord_v[FRAC_W-1:0] : '0;
            blend_en <= bil_sel;
        end
    end
endmodule

// File: rtl/texel_fetch_plan_chk.sv
// Protocol and output-relation checks for texel_fetch_plan, bound to it.
module texel_fetch_plan_chk #(
    parameter int COORD_W = 18,
    parameter int RES_W   = 11,
    parameter int ADDR_W  = 32,
    parameter int MASK_W  = 6 + RES_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [ADDR_W-1:0]   tex_base,
    input logic [MASK_W-1:0]   tex_hmask,
    input logic                out_valid,
    input logic                out_ready,
    input logic [ADDR_W-1:0]   texel_a,
    input logic [ADDR_W-1:0]   texel_b,
    input logic [ADDR_W-1:0]   texel_c,
    input logic [ADDR_W-1:0]   texel_d,
    input logic [5:0]          weight_u,
    input logic [5:0]          weight_v,
    input logic                blend_en
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(texel_a) && $stable(texel_b)
            && $stable(texel_c) && $stable(texel_d) && $stable(weight_u)
            && $stable(weight_v) && $stable(blend_en));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R9
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R3
    nearest_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !blend_en |-> weight_u == 6'd0 && weight_v == 6'd0
            && texel_b == texel_a && texel_c == texel_a && texel_d == texel_a);

    // R2
    filter_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> blend_en == ($past(tex_hmask[5:0]) > 6'h20));

    // R8
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> texel_a[0] == $past(tex_base[0])
            && texel_d[0] == $past(tex_base[0]));
endmodule

bind texel_fetch_plan texel_fetch_plan_chk #(
    .COORD_W(COORD_W), .RES_W(RES_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W)
) chk_i (.*);

// File: tb/texel_fetch_plan_tb_top.sv
`timescale 1ns/1ps
module texel_fetch_plan_tb_top;
    localparam int COORD_W = 12;
    localparam int RES_W   = 4;
    localparam int ADDR_W  = 16;
    localparam int MASK_W  = 6 + RES_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [COORD_W-1:0] coord_u = '0, coord_v = '0;
    logic [ADDR_W-1:0]  tex_base = '0;
    logic [RES_W-1:0]   tex_hres = '0, tex_vres = '0;
    logic [MASK_W-1:0]  tex_hmask = '0, tex_vmask = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [ADDR_W-1:0] texel_a, texel_b, texel_c, texel_d;
    logic [5:0] weight_u, weight_v;
    logic blend_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    texel_fetch_plan #(.COORD_W(COORD_W), .RES_W(RES_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .coord_u(coord_u), .coord_v(coord_v), .tex_base(tex_base),
        .tex_hres(tex_hres), .tex_vres(tex_vres), .tex_hmask(tex_hmask),
        .tex_vmask(tex_vmask), .out_valid(out_valid), .out_ready(out_ready),
        .texel_a(texel_a), .texel_b(texel_b), .texel_c(texel_c), .texel_d(texel_d),
        .weight_u(weight_u), .weight_v(weight_v), .blend_en(blend_en));

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected axis rule (R6, R7, R10)
    function automatic int fold(input int i, input int res, input bit clamp);
        if (res == 0) return 0;
        if (clamp) return (i < 0) ? 0 : ((i >= res) ? res - 1 : i);
        return ((i % res) + res) % res;
    endfunction

    function automatic longint exp_addr(input int x, input int y);
        return (longint'(tex_base) + 2 * (y * int'(tex_hres) + x)) & ((1 << ADDR_W) - 1);
    endfunction

    // One request: drive, capture, compare, optionally stall the output.
    task automatic run_one(input int ui, input int uf, input int vi, input int vf, input bit stall);
        bit bil, hc, vc;
        int x0, x1, y0, y1;
        string mt, at;
        logic [ADDR_W-1:0] held;
        bil = tex_hmask[5:0] > 6'h20;
        hc  = ((tex_hmask >> 6) & MASK_W'(tex_hres)) != 0;
        vc  = ((tex_vmask >> 6) & MASK_W'(tex_vres)) != 0;
        x0 = fold(ui, tex_hres, hc);
        x1 = fold(bil ? ui + 1 : ui, tex_hres, hc);
        y0 = fold(vi, tex_vres, vc);
        y1 = fold(bil ? vi + 1 : vi, tex_vres, vc);
        mt = bil ? "R4" : "R3";
        at = $sformatf("%s R5 R8 h:%s v:%s", mt, hc ? "R7" : "R6", vc ? "R7" : "R6");
        @(negedge clk);
        in_valid = 1'b1;
        coord_u  = COORD_W'(ui * 64 + uf);
        coord_v  = COORD_W'(vi * 64 + vf);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R9 latency", out_valid, 1);
        check(blend_en == bil, "R2 blend flag", blend_en, bil);
        check(texel_a == exp_addr(x0, y0), {at, " a"}, texel_a, exp_addr(x0, y0));
        check(texel_b == exp_addr(x1, y0), {at, " b"}, texel_b, exp_addr(x1, y0));
        check(texel_c == exp_addr(x0, y1), {at, " c"}, texel_c, exp_addr(x0, y1));
        check(texel_d == exp_addr(x1, y1), {at, " d"}, texel_d, exp_addr(x1, y1));
        check(weight_u == (bil ? 6'(uf) : 6'd0), {mt, " weight_u"}, weight_u, bil ? uf : 0);
        check(weight_v == (bil ? 6'(vf) : 6'd0), {mt, " weight_v"}, weight_v, bil ? vf : 0);
        if (stall) begin
            held = texel_d;
            out_ready = 1'b0;
            in_valid  = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check(out_valid == 1'b1 && in_ready == 1'b0, "R9 stall blocks", in_ready, 0);
            check(texel_d == held, "R9 stall hold", texel_d, held);
            in_valid  = 1'b0;
            out_ready = 1'b1;
        end
    endtask

    initial begin
        int hres_l[5] = '{1, 3, 5, 8, 15};
        int vres_l[3] = '{1, 4, 7};
        int n = 0;
        repeat (3) @(negedge clk);
        // R1
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1 idle after reset", in_ready, 1);

        foreach (hres_l[hi]) foreach (vres_l[vi]) for (int m = 0; m < 8; m++) begin
            tex_hres = RES_W'(hres_l[hi]);
            tex_vres = RES_W'(vres_l[vi]);
            tex_base = ADDR_W'(16'h1000 + 2 * (hi * 37 + vi * 11));
            tex_hmask = {(m[0] ? tex_hres : ~tex_hres), (m[2] ? 6'h21 + 6'(m * 3) : 6'h20 - 6'(m * 4))};
            tex_vmask = {(m[1] ? tex_vres : ~tex_vres), 6'h00};
            for (int ui = -32; ui < 32; ui += 5)
                for (int vv = -32; vv < 32; vv += 7) begin
                    n++;
                    run_one(ui, (ui * 7 + vv * 3) & 63, vv, (ui * 5 + vv) & 63, (n % 97) == 0);
                end
        end

        // R2 threshold: 0x20 nearest, 0x21 bilinear
        tex_hres = 4'd6; tex_vres = 4'd6; tex_base = 16'h0200;
        tex_vmask = '0;
        tex_hmask = {4'd0, 6'h20};
        run_one(2, 33, 3, 17, 1'b0);
        tex_hmask = {4'd0, 6'h21};
        run_one(5, 63, 5, 1, 1'b0);
        // R5: mask bits not overlapping resolution leave the axis wrapping
        tex_hmask = {4'b1001, 6'h3F};
        tex_vmask = {4'b1001, 6'h00};
        run_one(7, 10, -1, 20, 1'b0);
        // R10: zero resolution on either axis
        tex_hres = 4'd0;
        run_one(9, 4, 2, 4, 1'b0);
        tex_hres = 4'd5; tex_vres = 4'd0;
        tex_hmask = {4'b0101, 6'h30};
        run_one(-3, 8, 6, 9, 1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule